// File: doc/BRIEF.md
# Signed Integer to Single-Precision Converter

This block turns a signed two's-complement integer into an IEEE-754 single-precision value and writes it into lane 0 (bits [31:0]) of a vector destination. The integer is 32 bits wide by default. It is 64 bits wide only when the 64-bit-mode flag and the wide-operand flag are both set. The result is normalised with a leading-zero count, rounded in one of four directions, and flagged as inexact when rounding changed the value.

The rounding direction comes from a global control field. A per-operation override replaces it when the override is enabled and the integer came from a register. The bits of the destination above lane 0 are built in one of two ways:
- **Three-operand style:** bits [127:32] are copied from a first source operand, and everything above bit 127 is cleared.
- **Legacy two-operand style:** every bit above bit 31 keeps its previous value.

An optional write-mask bit can suppress the lane-0 write. Results appear one clock after a valid input, together with an output valid strobe.

Top module: `int2sp_cvt`

## Requirements
- R1: With `mode64`=1 and `wide_op`=1 all 64 bits of `src_int` are converted as a signed value. Otherwise `src_int[31:0]` alone is converted as a signed 32-bit value, and bits [63:32] have no effect on any output.
- R2: With `mode64`=0, `wide_op` has no effect: the outputs are the same as with `wide_op`=0.
- R3: `dest_out[31:0]` holds the IEEE-754 single-precision result, with sign in bit 31, biased exponent (bias 127) in bits [30:23] and fraction in bits [22:0]. A zero input gives 0x00000000. The most negative 32-bit value gives 0xCF000000 exactly, and the most negative 64-bit value gives 0xDF000000 exactly.
- R4: With `three_op`=1, `dest_out[127:32]` equals `src1_hi` and `dest_out[VEC_W-1:128]` is zero.
- R5: With `three_op`=0, `dest_out[VEC_W-1:32]` equals `dest_old[VEC_W-1:32]`.
- R6: The rounding field encodes 00 nearest-even, 01 toward negative infinity, 10 toward positive infinity and 11 toward zero. By default `rc_global` selects the direction.
- R7: `rc_override` replaces `rc_global` only when `rc_override_en`=1 and `src_is_reg`=1. In every other case it has no effect.
- R8: `inexact` is 1 exactly when the rounded result differs from the integer value. It is never 1 for magnitudes below 2^24.
- R9: When `mask_en`=1 and `mask_bit`=0, `dest_out[31:0]` equals `dest_old[31:0]` and `inexact` is 0. When `mask_en`=0, or `mask_bit`=1, lane 0 is written.
- R10: After reset, `out_valid`, `inexact` and `dest_out` are 0. `out_valid` follows `in_valid` one cycle later. Without `in_valid`, `dest_out` and `inexact` hold their values.
- R11: A rounding carry out of the 24-bit significand increments the exponent. For example, 0x01FFFFFF rounded to nearest gives 0x4C000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| mode64 | input | 1 | 64-bit mode active |
| wide_op | input | 1 | Request for a 64-bit integer source |
| src_int | input | SRC_W | Signed integer source |
| src_is_reg | input | 1 | Integer source came from a register |
| rc_global | input | 2 | Global rounding control |
| rc_override_en | input | 1 | Per-operation rounding override enable |
| rc_override | input | 2 | Per-operation rounding control |
| three_op | input | 1 | 1: three-operand style, 0: legacy style |
| src1_hi | input | XMM_W-LANE_W | Bits [127:32] of the first source operand |
| dest_old | input | VEC_W | Previous destination contents |
| mask_en | input | 1 | Masked form in use |
| mask_bit | input | 1 | Write-mask bit for lane 0 |
| out_valid | output | 1 | Result valid |
| dest_out | output | VEC_W | New destination value |
| inexact | output | 1 | Precision (inexact) flag |

## Verification
Small integers below 2^24 show that exact conversions never raise the flag. The integers 2^24+1 and 2^24+3 fall exactly halfway between two representable values, which separates ties-to-even from the other three directions. Values such as 0x01FFFFFF drive the significand carry into the exponent. The two most negative integers and zero show that the sign handling is correct.

Upper-half garbage on the 32-bit path and a set wide flag outside 64-bit mode tell the width selection apart. Override attempts with a memory source separate the two rounding sources. Long random runs mix every style, mask and rounding combination, and idle cycles between them show that the outputs hold.

// File: rtl/int2sp_pkg.sv
package int2sp_pkg;

  // Rounding direction encoding shared by the global and override fields
  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_DOWN      = 2'b01,
    RND_UP        = 2'b10,
    RND_ZERO      = 2'b11
  } rnd_mode_e;

  localparam int SP_W     = 32;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int SP_SIG_W = SP_MAN_W + 1;
  localparam int SP_BIAS  = 127;

  typedef struct packed {
    logic                sign;
    logic [SP_EXP_W-1:0] exp;
    logic [SP_MAN_W-1:0] frac;
  } sp_word_t;

endpackage

// File: rtl/int2sp_lzc.sv
module int2sp_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  // Scan upward so the highest set bit writes last
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/int2sp_round.sv
module int2sp_round
  import int2sp_pkg::*;
#(
  parameter int IN_W = 64
) (
  input  logic            sign,
  input  logic [IN_W-1:0] mag,
  input  rnd_mode_e       mode,
  output sp_word_t        res,
  output logic            inexact
);
  localparam int LZ_W   = $clog2(IN_W) + 1;
  localparam int TOP_E  = SP_BIAS + IN_W - 1;
  localparam int LOW_W  = IN_W - SP_SIG_W - 2;

  logic [LZ_W-1:0]     lz;
  logic [IN_W-1:0]     norm;
  logic [SP_SIG_W-1:0] sig;
  logic                guard_b, round_b, sticky_b, lsb_b, bump;
  logic [SP_SIG_W:0]   sum;
  logic [8:0]          exp_pre, exp_fin;
  logic                is_zero;

  int2sp_lzc #(.W(IN_W), .CW(LZ_W)) u_lzc (.vec(mag), .count(lz));

  always_comb begin
    is_zero  = (mag == '0);
    norm     = mag << lz;
    sig      = norm[IN_W-1 -: SP_SIG_W];
    guard_b  = norm[IN_W-SP_SIG_W-1];
    round_b  = norm[IN_W-SP_SIG_W-2];
    sticky_b = |norm[LOW_W-1:0];
    lsb_b    = sig[0];
    inexact  = guard_b | round_b | sticky_b;
    unique case (mode)
      RND_NEAR_EVEN: bump = guard_b & (round_b | sticky_b | lsb_b);
      RND_DOWN:      bump = inexact & sign;
      RND_UP:        bump = inexact & ~sign;
      default:       bump = 1'b0;
    endcase
    sum     = {1'b0, sig} + {{SP_SIG_W{1'b0}}, bump};
    exp_pre = 9'(TOP_E) - 9'(lz);
    exp_fin = sum[SP_SIG_W] ? exp_pre + 9'd1 : exp_pre;
    res.sign = sign;
    res.exp  = exp_fin[SP_EXP_W-1:0];
    res.frac = sum[SP_SIG_W] ? sum[SP_SIG_W-1:1] : sum[SP_MAN_W-1:0];
    if (is_zero) begin
      res     = '0;
      inexact = 1'b0;
    end
  end
endmodule

// File: rtl/int2sp_lane_merge.sv
module int2sp_lane_merge #(
  parameter int VEC_W  = 256,
  parameter int XMM_W  = 128,
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0]       low_lane,
  input  logic                    write_low,
  input  logic                    three_op,
  input  logic [XMM_W-LANE_W-1:0] src1_hi,
  input  logic [VEC_W-1:0]        dest_old,
  output logic [VEC_W-1:0]        vec_out
);
  always_comb begin
    if (three_op) begin
      vec_out = '0;
      vec_out[XMM_W-1:LANE_W] = src1_hi;
    end else begin
      vec_out = dest_old;
    end
    vec_out[LANE_W-1:0] = write_low ? low_lane : dest_old[LANE_W-1:0];
  end
endmodule

// File: rtl/int2sp_cvt.sv
module int2sp_cvt
  import int2sp_pkg::*;
#(
  parameter int SRC_W    = 64,
  parameter int NARROW_W = 32,
  parameter int VEC_W    = 256,
  parameter int XMM_W    = 128,
  parameter int LANE_W   = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    mode64,
  input  logic                    wide_op,
  input  logic [SRC_W-1:0]        src_int,
  input  logic                    src_is_reg,
  input  logic [1:0]              rc_global,
  input  logic                    rc_override_en,
  input  logic [1:0]              rc_override,
  input  logic                    three_op,
  input  logic [XMM_W-LANE_W-1:0] src1_hi,
  input  logic [VEC_W-1:0]        dest_old,
  input  logic                    mask_en,
  input  logic                    mask_bit,
  output logic                    out_valid,
  output logic [VEC_W-1:0]        dest_out,
  output logic                    inexact
);
  localparam int EXT_W = SRC_W - NARROW_W;

  logic             use_wide, sgn, write_low, cv_inexact;
  logic [SRC_W-1:0] ext, mag;
  rnd_mode_e        eff_rc;
  sp_word_t         cv_res;
  logic [VEC_W-1:0] merged;

  always_comb begin
    use_wide  = mode64 & wide_op;
    ext       = use_wide ? src_int
                         : {{EXT_W{src_int[NARROW_W-1]}}, src_int[NARROW_W-1:0]};
    sgn       = ext[SRC_W-1];
    mag       = sgn ? (~ext + 1'b1) : ext;
    eff_rc    = rnd_mode_e'((rc_override_en & src_is_reg) ? rc_override : rc_global);
    write_low = ~mask_en | mask_bit;
  end

  int2sp_round #(.IN_W(SRC_W)) u_round (
    .sign(sgn), .mag(mag), .mode(eff_rc), .res(cv_res), .inexact(cv_inexact)
  );

  int2sp_lane_merge #(.VEC_W(VEC_W), .XMM_W(XMM_W), .LANE_W(LANE_W)) u_merge (
    .low_lane(cv_res), .write_low(write_low), .three_op(three_op),
    .src1_hi(src1_hi), .dest_old(dest_old), .vec_out(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dest_out  <= '0;
      inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dest_out <= merged;
        inexact  <= cv_inexact & write_low;
      end
    end
  end

  // Output strobe trails the input strobe by one cycle
  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_three_op_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(three_op)) |-> dest_out[XMM_W-1:LANE_W] == $past(src1_hi));

  assert_legacy_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(three_op)) |-> dest_out[VEC_W-1:LANE_W] == $past(dest_old[VEC_W-1:LANE_W]));

  assert_masked_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mask_en && !mask_bit)) |->
      (dest_out[LANE_W-1:0] == $past(dest_old[LANE_W-1:0]) && !inexact));

  // Rounding can only lose bits once the magnitude reaches 2^24
  assert_inexact_range_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && inexact) |-> dest_out[30:23] >= 8'd151);

  generate
    if (VEC_W > XMM_W) begin : g_hi_zero
      assert_three_op_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(three_op)) |-> dest_out[VEC_W-1:XMM_W] == '0);
    end
  endgenerate
endmodule

// File: tb/int2sp_cvt_test.sv
module int2sp_cvt_test;
  localparam int VEC_W = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0, mode64 = 1'b0, wide_op = 1'b0, src_is_reg = 1'b0;
  logic [63:0]       src_int = '0;
  logic [1:0]        rc_global = '0, rc_override = '0;
  logic              rc_override_en = 1'b0, three_op = 1'b0, mask_en = 1'b0, mask_bit = 1'b0;
  logic [95:0]       src1_hi = '0;
  logic [VEC_W-1:0]  dest_old = '0;
  logic              out_valid, inexact;
  logic [VEC_W-1:0]  dest_out;

  int vectors = 0, errors = 0;
  logic             m_valid = 1'b0, m_inx = 1'b0;
  logic [VEC_W-1:0] m_dest = '0;

  always #2.5 clk = ~clk;

  int2sp_cvt uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode64(mode64), .wide_op(wide_op),
    .src_int(src_int), .src_is_reg(src_is_reg), .rc_global(rc_global),
    .rc_override_en(rc_override_en), .rc_override(rc_override), .three_op(three_op),
    .src1_hi(src1_hi), .dest_old(dest_old), .mask_en(mask_en), .mask_bit(mask_bit),
    .out_valid(out_valid), .dest_out(dest_out), .inexact(inexact)
  );

  function automatic logic [VEC_W-1:0] rand_vec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < VEC_W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // Behavioural reference: exact remainder compared against one half ulp
  task automatic ref_conv(input logic [63:0] v, input logic [1:0] rc,
                          output logic [31:0] res, output logic inx);
    logic        neg;
    logic [63:0] m, q, rem, half;
    int          p, s, e;
    neg = v[63];
    m   = neg ? (64'd0 - v) : v;
    inx = 1'b0;
    if (m == 0) begin
      res = 32'h0;
      return;
    end
    p = 0;
    for (int i = 0; i < 64; i++) if (m[i]) p = i;
    e = 127 + p;
    if (p <= 23) begin
      q = m << (23 - p);
    end else begin
      s    = p - 23;
      q    = m >> s;
      rem  = m & ((64'd1 << s) - 64'd1);
      half = 64'd1 << (s - 1);
      inx  = (rem != 0);
      case (rc)
        2'b00: if (rem > half || (rem == half && q[0])) q = q + 1;
        2'b01: if (inx && neg) q = q + 1;
        2'b10: if (inx && !neg) q = q + 1;
        default: ;
      endcase
      if (q == (64'd1 << 24)) begin
        q = q >> 1;
        e = e + 1;
      end
    end
    res = {neg, 8'(e), q[22:0]};
  endtask

  task automatic check(input string tag);
    vectors++;
    if (out_valid !== m_valid || dest_out !== m_dest || inexact !== m_inx) begin
      errors++;
      $display("FAIL %s: got valid=%b inx=%b dest=%h, expected valid=%b inx=%b dest=%h",
               tag, out_valid, inexact, dest_out, m_valid, m_inx, m_dest);
    end
  endtask

  // Predict next state from current inputs, let one edge pass, compare
  task automatic cycle(input string tag);
    logic [63:0]      v;
    logic [1:0]       rc;
    logic [31:0]      r;
    logic             x, wr;
    logic [VEC_W-1:0] nd;
    if (in_valid) begin
      v  = (mode64 && wide_op) ? src_int : {{32{src_int[31]}}, src_int[31:0]};
      rc = (rc_override_en && src_is_reg) ? rc_override : rc_global;
      ref_conv(v, rc, r, x);
      wr = !mask_en || mask_bit;
      if (three_op) begin
        nd = '0;
        nd[127:32] = src1_hi;
      end else begin
        nd = dest_old;
      end
      nd[31:0] = wr ? r : dest_old[31:0];
      m_dest = nd;
      m_inx  = x && wr;
    end
    m_valid = in_valid;
    @(negedge clk);
    check(tag);
  endtask

  task automatic op(input string tag, input logic [63:0] s, input logic m64, input logic wd,
                    input logic [1:0] rcg, input logic ove, input logic [1:0] rco,
                    input logic isreg, input logic three, input logic men, input logic mb);
    in_valid = 1'b1; src_int = s; mode64 = m64; wide_op = wd; rc_global = rcg;
    rc_override_en = ove; rc_override = rco; src_is_reg = isreg; three_op = three;
    mask_en = men; mask_bit = mb; src1_hi = 96'(rand_vec()); dest_old = rand_vec();
    cycle(tag);
  endtask

  task automatic idle(input string tag);
    in_valid = 1'b0; src_int = {$urandom, $urandom}; dest_old = rand_vec();
    src1_hi = 96'(rand_vec()); three_op = 1'b1;
    cycle(tag);
  endtask

  initial begin
    for (int i = 0; i < 250000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset state");
    // R3 special values
    op("R3 zero",        64'h0,                 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    op("R3 min32",       64'h0000_0000_8000_0000, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    op("R3 min64",       64'h8000_0000_0000_0000, 1'b1, 1'b1, 2'b11, 1'b0, 2'b00, 1'b1, 0, 1'b0, 1'b0);
    // R1 width selection
    op("R1 wide64",      64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    op("R1 upper ignored", 64'hDEAD_BEEF_0000_0005, 1'b1, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    // R2 wide flag outside 64-bit mode
    op("R2 wide ignored", 64'h1234_5678_FFFF_FFFD, 1'b0, 1'b1, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    // R6 tie cases under each direction
    for (int k = 0; k < 4; k++) begin
      op("R6 tie 2^24+1", 64'h0100_0001, 1'b0, 1'b0, 2'(k), 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
      op("R6 tie 2^24+3", 64'h0100_0003, 1'b0, 1'b0, 2'(k), 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
      op("R6 neg inexact", 64'hFEFF_FFFF, 1'b0, 1'b0, 2'(k), 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    end
    // R7 override with register and memory sources
    op("R7 override reg", 64'h0100_0001, 1'b0, 1'b0, 2'b00, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
    op("R7 override mem", 64'h0100_0001, 1'b0, 1'b0, 2'b00, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
    // R11 carry into exponent
    op("R11 carry",      64'h01FF_FFFF, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    op("R11 carry up",   64'h00FF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 2'b10, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    // R8 exact below 2^24
    op("R8 exact",       64'h00FF_FFFF, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    // R9 masking
    op("R9 masked off",  64'h0100_0001, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
    op("R9 masked on",   64'h0100_0001, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1);
    // R4 / R5 styles
    op("R4 three-op",    64'h0000_0007, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    op("R5 legacy",      64'h0000_0007, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    // R10 hold on idle
    idle("R10 hold");
    idle("R10 hold");
    // Random mix, idle cycles interleaved
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] s;
      s = {$urandom, $urandom};
      if (n % 3 == 0) s = s >> ($urandom % 64);
      if ($urandom % 7 == 0) idle("R10 random idle");
      else op("R8 random", s, 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
              2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    idle("R10 final");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule